// File: doc/BRIEF.md
# Multi-Responder Reply Combiner

This block sits at a requesting core in a system of `NUM_CORES` cores. When the core issues an invalidation, each other core that answers returns a store-point value together with one unsafe flag per word of the cache line. The combiner is told how many answers to expect, gathers them one per cycle in whatever order they arrive, and folds them into one conservative summary. The requesting core then uses this summary to set the store point of its pending store and records it against the line.

An answer whose unsafe flags are all clear shows that the responder's accesses to the line are already ordered, so it is left out of the merge. The answers that remain are merged word by word with a logical OR of their unsafe flags. Their store points are merged by taking the latest one, where "latest" uses the same wrap-around ordering as the history buffer. If no answer remains, or none is expected (a line filled by a read miss), the summary is all zero. The result stays on the output until it is consumed, and the next request is not taken before that.

Top module: `reply_combiner`

## Requirements
- R1: After reset `req_ready` is 1 and `out_valid` is 0.
- R2: A request is accepted only when `req_ready` is 1. From the accepting edge until the result is consumed, `req_ready` is 0, and a `req_valid` pulse in that period has no effect on the result. `req_count` must not exceed `NUM_CORES-1`.
- R3: With `req_count` = n > 0, `out_valid` rises in the cycle after the edge at which the n-th reply (`rsp_valid` high while collecting) is accepted. Gaps between replies are allowed. A `rsp_valid` pulse while no request is being collected is ignored.
- R4: With `req_count` = 0, `out_valid` rises in the cycle after the request is accepted, with `out_unsafe` = 0 and `out_sp` = 0.
- R5: A reply whose `rsp_unsafe` bits are all 0 changes neither `out_sp` nor `out_unsafe`.
- R6: Bit m of `out_unsafe` is the OR of bit m over all retained replies.
- R7: `out_sp` is the latest `rsp_sp` among the retained replies. Value a is later than value b when (a-b) mod 2^SP_W, read as a signed SP_W-bit number, is positive. Retained values are assumed to lie within a window narrower than 2^(SP_W-1).
- R8: If no reply is retained, `out_unsafe` = 0 and `out_sp` = 0.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_sp` and `out_unsafe` stay unchanged. An edge with both `out_valid` and `out_ready` high clears `out_valid` and raises `req_ready` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start collecting for a new invalidation |
| req_ready | output | 1 | Combiner idle, request can be taken |
| req_count | input | $clog2(NUM_CORES) | Number of replies to expect |
| rsp_valid | input | 1 | One reply present this cycle |
| rsp_sp | input | SP_W | Store point carried by the reply |
| rsp_unsafe | input | WORDS | Per-word unsafe flags of the reply |
| out_valid | output | 1 | Merged summary ready |
| out_ready | input | 1 | Consumer takes the summary |
| out_sp | output | SP_W | Merged store point |
| out_unsafe | output | WORDS | Merged per-word unsafe flags |

## Verification
The bench runs a small setup (four cores, two words, four-bit store points) through every reply count from zero to three. For each count it tries every combination of per-reply unsafe patterns, so all-clear replies appear at each arrival position, which shows that exclusion depends on the flags and not on arrival order. The store points move through a window that crosses the wrap from 15 to 0, which tells a wrap-aware maximum apart from a plain unsigned one. Replies sent while idle, request pulses while busy, gaps between replies and a held-off consumer show that stray inputs are ignored and that the result stays put.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [1:0] {
    RC_IDLE    = 2'd0,
    RC_COLLECT = 2'd1,
    RC_DONE    = 2'd2
  } rc_state_e;
endpackage

// File: rtl/rc_ctrl.sv
module rc_ctrl #(
  parameter int NUM_CORES = 8,
  localparam int CNT_W = (NUM_CORES > 2) ? $clog2(NUM_CORES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [CNT_W-1:0] req_count,
  input  logic             rsp_valid,
  input  logic             out_ready,
  output logic             req_ready,
  output logic             start_clr,
  output logic             rsp_take,
  output logic             out_valid
);
  import rc_pkg::*;

  rc_state_e        state_q, state_d;
  logic [CNT_W-1:0] seen_q;
  logic [CNT_W-1:0] want_q;
  logic             last_rsp;
  logic             out_fire;

  assign req_ready = (state_q == RC_IDLE);
  assign out_valid = (state_q == RC_DONE);
  assign start_clr = req_ready && req_valid;
  assign rsp_take  = (state_q == RC_COLLECT) && rsp_valid;
  assign out_fire  = out_valid && out_ready;
  assign last_rsp  = rsp_take && (({1'b0, seen_q} + 1'b1) == {1'b0, want_q});

  always_comb begin
    state_d = state_q;
    case (state_q)
      RC_IDLE:    if (start_clr) state_d = (req_count == '0) ? RC_DONE : RC_COLLECT;
      RC_COLLECT: if (last_rsp)  state_d = RC_DONE;
      RC_DONE:    if (out_fire)  state_d = RC_IDLE;
      default:                   state_d = RC_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RC_IDLE;
      seen_q  <= '0;
      want_q  <= '0;
    end else begin
      state_q <= state_d;
      if (start_clr) begin
        seen_q <= '0;
        want_q <= req_count;
      end else if (rsp_take) begin
        seen_q <= seen_q + 1'b1;
      end
    end
  end

  // R2
  req_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_clr |-> (int'(req_count) <= NUM_CORES - 1));

  // R3
  seen_below_want_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RC_COLLECT) |-> (seen_q < want_q));

  // R2
  busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take || (out_valid && !out_ready)) |=> !req_ready);

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire |=> (req_ready && !out_valid));
endmodule

// File: rtl/rc_merge.sv
module rc_merge #(
  parameter int WORDS = 4,
  parameter int SP_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_clr,
  input  logic             rsp_take,
  input  logic [SP_W-1:0]  rsp_sp,
  input  logic [WORDS-1:0] rsp_unsafe,
  output logic [SP_W-1:0]  acc_sp,
  output logic [WORDS-1:0] acc_unsafe,
  output logic             acc_any
);
  // a is later than b when the modular difference is positive as a signed value
  function automatic logic sp_later(input logic [SP_W-1:0] a, input logic [SP_W-1:0] b);
    logic [SP_W-1:0] diff;
    diff = a - b;
    return (diff != '0) && !diff[SP_W-1];
  endfunction

  logic rsp_keep;
  logic merge_en;
  logic sp_replace;

  assign rsp_keep   = |rsp_unsafe;
  assign merge_en   = rsp_take && rsp_keep;
  assign sp_replace = !acc_any || sp_later(rsp_sp, acc_sp);

  for (genvar m = 0; m < WORDS; m++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)         acc_unsafe[m] <= 1'b0;
      else if (start_clr) acc_unsafe[m] <= 1'b0;
      else if (merge_en)  acc_unsafe[m] <= acc_unsafe[m] | rsp_unsafe[m];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_sp  <= '0;
      acc_any <= 1'b0;
    end else if (start_clr) begin
      acc_sp  <= '0;
      acc_any <= 1'b0;
    end else if (merge_en) begin
      acc_any <= 1'b1;
      if (sp_replace) acc_sp <= rsp_sp;
    end
  end

  // R5
  drop_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && !rsp_keep && !start_clr) |=> ($stable(acc_sp) && $stable(acc_unsafe)));

  // R6
  unsafe_superset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    merge_en |=> ((acc_unsafe & $past(rsp_unsafe)) == $past(rsp_unsafe)));

  // R7
  sp_not_earlier_chk: assert property (@(posedge clk) disable iff (!rst_n)
    merge_en |=> !sp_later($past(rsp_sp), acc_sp));

  // R8
  empty_is_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_any |-> (acc_sp == '0 && acc_unsafe == '0));
endmodule

// File: rtl/reply_combiner.sv
module reply_combiner #(
  parameter int NUM_CORES = 8,
  parameter int WORDS     = 4,
  parameter int SP_W      = 16,
  localparam int CNT_W = (NUM_CORES > 2) ? $clog2(NUM_CORES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CNT_W-1:0] req_count,
  input  logic             rsp_valid,
  input  logic [SP_W-1:0]  rsp_sp,
  input  logic [WORDS-1:0] rsp_unsafe,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SP_W-1:0]  out_sp,
  output logic [WORDS-1:0] out_unsafe
);
  logic start_clr;
  logic rsp_take;
  logic acc_any;

  rc_ctrl #(.NUM_CORES(NUM_CORES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_count (req_count),
    .rsp_valid (rsp_valid),
    .out_ready (out_ready),
    .req_ready (req_ready),
    .start_clr (start_clr),
    .rsp_take  (rsp_take),
    .out_valid (out_valid)
  );

  rc_merge #(.WORDS(WORDS), .SP_W(SP_W)) u_merge (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_clr  (start_clr),
    .rsp_take   (rsp_take),
    .rsp_sp     (rsp_sp),
    .rsp_unsafe (rsp_unsafe),
    .acc_sp     (out_sp),
    .acc_unsafe (out_unsafe),
    .acc_any    (acc_any)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (req_ready && !out_valid));

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sp) && $stable(out_unsafe)));

  // R2
  one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && out_valid));
endmodule

// File: tb/tb_reply_combiner.sv
module tb_reply_combiner;
  localparam int N  = 4;
  localparam int W  = 2;
  localparam int SW = 4;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [CW-1:0] req_count = '0;
  logic          rsp_valid = 1'b0;
  logic [SW-1:0] rsp_sp = '0;
  logic [W-1:0]  rsp_unsafe = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [SW-1:0] out_sp;
  logic [W-1:0]  out_unsafe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  reply_combiner #(.NUM_CORES(N), .WORDS(W), .SP_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_count(req_count), .rsp_valid(rsp_valid), .rsp_sp(rsp_sp),
    .rsp_unsafe(rsp_unsafe), .out_valid(out_valid), .out_ready(out_ready),
    .out_sp(out_sp), .out_unsafe(out_unsafe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // signed modular distance, restated from R7
  function automatic int sdist(input int a, input int b);
    int d;
    d = (a - b) & ((1 << SW) - 1);
    if (d >= (1 << (SW - 1))) d = d - (1 << SW);
    return d;
  endfunction

  int us[3];
  int sps[3];

  task automatic run_txn(input int n, input int p);
    int exp_u, exp_sp;
    bit any;
    any = 1'b0; exp_u = 0; exp_sp = 0;
    for (int i = 0; i < n; i++) begin
      if (us[i] != 0) begin
        exp_u = exp_u | us[i];
        if (!any || sdist(sps[i], exp_sp) > 0) exp_sp = sps[i];
        any = 1'b1;
      end
    end
    // stray reply while idle (R3)
    if (p % 5 == 0) begin
      rsp_valid = 1'b1; rsp_unsafe = '1; rsp_sp = SW'(exp_sp + 5);
      @(negedge clk);
      rsp_valid = 1'b0;
    end
    chk(req_ready === 1'b1, "R2 idle ready", int'(req_ready), 1);
    req_valid = 1'b1; req_count = CW'(n);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      chk(req_ready === 1'b0 && out_valid === 1'b0, "R3 busy before last reply",
          int'(out_valid), 0);
      if (p % 3 == 1) @(negedge clk);
      rsp_valid = 1'b1; rsp_unsafe = W'(us[i]); rsp_sp = SW'(sps[i]);
      if (i == 0 && p % 4 == 2) begin
        req_valid = 1'b1; req_count = '0;
      end
      @(negedge clk);
      rsp_valid = 1'b0; req_valid = 1'b0;
    end
    if (n == 0)
      chk(out_valid === 1'b1 && out_unsafe == '0 && out_sp == '0, "R4 empty request",
          int'(out_valid), 1);
    else
      chk(out_valid === 1'b1, "R3 valid after last reply", int'(out_valid), 1);
    chk(int'(out_unsafe) == exp_u, (any ? "R6 merged unsafe" : "R8 no retained unsafe"),
        int'(out_unsafe), exp_u);
    chk(int'(out_sp) == exp_sp, (any ? "R7 merged store point" : "R5 dropped store point"),
        int'(out_sp), exp_sp);
    // hold while not consumed, with stray inputs (R9, R3, R2)
    rsp_valid = 1'b1; rsp_unsafe = '1; rsp_sp = SW'(exp_sp + 3);
    req_valid = 1'b1; req_count = 2'd1;
    @(negedge clk);
    rsp_valid = 1'b0; req_valid = 1'b0;
    chk(out_valid === 1'b1 && int'(out_sp) == exp_sp && int'(out_unsafe) == exp_u,
        "R9 held result", int'(out_sp), exp_sp);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid === 1'b0 && req_ready === 1'b1, "R9 consumed", int'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && out_valid === 1'b0, "R1 reset outputs", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && out_valid === 1'b0, "R1 after reset release", int'(req_ready), 1);
    for (int n = 0; n < N; n++) begin
      for (int p = 0; p < (1 << (2 * n)); p++) begin
        int base;
        base = (p * 5 + n * 3) % 16;
        for (int i = 0; i < 3; i++) begin
          us[i]  = (p >> (2 * i)) & 3;
          sps[i] = (base + (((p >> i) * 3 + i * 2) % 6)) % 16;
        end
        run_txn(n, p);
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule